// File: doc/BRIEF.md
# Timer Event Flag Register

This block keeps the sticky status flags of a four-channel timer. Each capture/compare channel has one flag. The counter has one overflow flag. A channel raises its flag with a one-cycle event pulse when a capture or compare happens, and the counter raises the overflow flag with a one-cycle rollover pulse. A flag stays set until software clears it.

Software sees two byte-wide registers on a simple strobe interface with address and data. The channel register holds the four channel flags in its low nibble. The overflow register holds the overflow flag in its top bit. Writing a one to a flag bit clears that flag. Writing a zero leaves the flag alone.

When the fast-clear input is high, the normal data accesses also clear flags. An access to a channel's capture/compare data address clears that channel's flag, and a read of the counter address clears the overflow flag. The flag outputs go to interrupt logic that sits outside this block.

Top module: `tflag_regs`

Each flag is a two-state machine with the states FLAG_IDLE and FLAG_HELD. It has four transitions:
- RAISE: FLAG_IDLE to FLAG_HELD, on a set pulse.
- DROP: FLAG_HELD to FLAG_IDLE, on a clear with no set in the same cycle.
- KEEP: FLAG_HELD stays in FLAG_HELD.
- REST: FLAG_IDLE stays in FLAG_IDLE.

## Requirements
- R1: After reset, all flag outputs are low, and both flag registers read 0x00.
- R2: A pulse on chan_evt[i] sets channel flag i on the next clock edge. The flag then stays set until a clear reaches it.
- R3: A write to address 0x6 clears channel flag i for every data bit i (i = 0..3) that is 1. Flags whose bit is 0 are unchanged.
- R4: An ovf_evt pulse sets the overflow flag on the next clock edge. A write to address 0x7 with data bit 7 set clears the overflow flag.
- R5: While rd_en is high, read data follows the address:
  - 0x6 returns the channel flags in bits 3..0, with zeros in bits 7..4.
  - 0x7 returns the overflow flag in bit 7, with zeros in bits 6..0.
  - Any other address returns 0x00.
  With rd_en low, the read data is 0x00.
- R6: Ones written to the reserved bits (bits 7..4 at 0x6, bits 6..0 at 0x7) change no flag.
- R7: With fast_clr high, a read or a write at channel data address i (0x0..0x3) clears channel flag i.
- R8: With fast_clr high, a read of the counter address 0x4 clears the overflow flag.
- R9: With fast_clr low, accesses to addresses 0x0..0x4 leave every flag unchanged.
- R10: When a set pulse and any clear reach the same flag in one cycle, the flag ends up set.
- R11: An event on a flag that is already set keeps it set, and leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_evt | input | 4 | One-cycle capture/compare event pulse per channel |
| ovf_evt | input | 1 | One-cycle counter rollover pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| fast_clr | input | 1 | Fast-clear mode enable |
| rdata | output | 8 | Read data (0x00 when this block is not selected) |
| chan_flags | output | 4 | Channel flags to interrupt logic |
| ovf_flag | output | 1 | Overflow flag to interrupt logic |

## Verification
The hardest case to reach from the ports is the same-cycle collision: an event pulse lands on exactly the flag that a write-one-to-clear, or a fast-clear access, is removing in that cycle. Directed steps build each collision on purpose. Some drive a pulse together with a clearing write to the flag register. Others drive it together with a fast-clear read or write of that channel's data address, or together with a counter read. A long random phase then mixes dense event pulses with strobes aimed at every address, with fast-clear toggling. This lets collisions also occur on several flags at once.

// File: rtl/tflag_pkg.sv
package tflag_pkg;

    // Two-state life of one sticky flag
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/tflag_cell.sv
module tflag_cell
    import tflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e st_q;
    flag_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: a set pulse always dominates a clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: begin
                if (set_i) begin
                    st_d = FLAG_HELD;          // RAISE
                end
            end
            FLAG_HELD: begin
                if (clr_i && !set_i) begin
                    st_d = FLAG_IDLE;          // DROP
                end
            end
            default: st_d = FLAG_IDLE;
        endcase
    end

    // Output
    always_comb begin
        flag_o = (st_q == FLAG_HELD);
    end

endmodule

// File: rtl/tflag_clr_dec.sv
module tflag_clr_dec #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CH_BASE   = 0,
    parameter int CNT_ADDR  = 4,
    parameter int FLG1_ADDR = 6,
    parameter int FLG2_ADDR = 7
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fast_clr,
    output logic [NUM_CH-1:0] chan_clr,
    output logic              ovf_clr
);

    localparam int OVF_BIT = DATA_W - 1;
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);
    localparam logic [ADDR_W-1:0] A_FLG1 = ADDR_W'(FLG1_ADDR);
    localparam logic [ADDR_W-1:0] A_FLG2 = ADDR_W'(FLG2_ADDR);

    logic w1c_ch;
    logic w1c_ovf;
    logic any_acc;

    always_comb begin
        w1c_ch  = wr_en && (addr == A_FLG1);
        w1c_ovf = wr_en && (addr == A_FLG2);
        any_acc = rd_en || wr_en;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(CH_BASE + i);
        always_comb begin
            chan_clr[i] = (w1c_ch && wdata[i])
                        || (fast_clr && any_acc && (addr == A_CH));
        end
    end

    always_comb begin
        ovf_clr = (w1c_ovf && wdata[OVF_BIT])
                || (fast_clr && rd_en && (addr == A_CNT));
    end

    // Bits between the channel nibble and the overflow bit are reserved
    logic unused_rsv;
    always_comb begin
        unused_rsv = ^wdata[OVF_BIT-1:NUM_CH];
    end

endmodule

// File: rtl/tflag_rdmux.sv
module tflag_rdmux #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int FLG1_ADDR = 6,
    parameter int FLG2_ADDR = 7
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] chan_flags,
    input  logic              ovf_flag,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_FLG1 = ADDR_W'(FLG1_ADDR);
    localparam logic [ADDR_W-1:0] A_FLG2 = ADDR_W'(FLG2_ADDR);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_FLG1) begin
                rdata[NUM_CH-1:0] = chan_flags;
            end else if (addr == A_FLG2) begin
                rdata[DATA_W-1] = ovf_flag;
            end
        end
    end

endmodule

// File: rtl/tflag_regs.sv
module tflag_regs #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CH_BASE   = 0,
    parameter int CNT_ADDR  = 4,
    parameter int FLG1_ADDR = 6,
    parameter int FLG2_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_evt,
    input  logic              ovf_evt,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fast_clr,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] chan_flags,
    output logic              ovf_flag
);

    logic [NUM_CH-1:0] chan_clr;
    logic              ovf_clr;

    tflag_clr_dec #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CH_BASE  (CH_BASE),
        .CNT_ADDR (CNT_ADDR),
        .FLG1_ADDR(FLG1_ADDR),
        .FLG2_ADDR(FLG2_ADDR)
    ) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .fast_clr(fast_clr),
        .chan_clr(chan_clr),
        .ovf_clr (ovf_clr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        tflag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (chan_evt[i]),
            .clr_i (chan_clr[i]),
            .flag_o(chan_flags[i])
        );
    end

    tflag_cell u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovf_evt),
        .clr_i (ovf_clr),
        .flag_o(ovf_flag)
    );

    tflag_rdmux #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FLG1_ADDR(FLG1_ADDR),
        .FLG2_ADDR(FLG2_ADDR)
    ) u_rd (
        .rd_en     (rd_en),
        .addr      (addr),
        .chan_flags(chan_flags),
        .ovf_flag  (ovf_flag),
        .rdata     (rdata)
    );

endmodule

// File: rtl/tflag_regs_chk.sv
module tflag_regs_chk #(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CNT_ADDR  = 4,
    parameter int FLG1_ADDR = 6,
    parameter int FLG2_ADDR = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_evt,
    input logic              ovf_evt,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              fast_clr,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] chan_flags,
    input logic              ovf_flag
);

    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);
    localparam logic [ADDR_W-1:0] A_FLG1 = ADDR_W'(FLG1_ADDR);
    localparam logic [ADDR_W-1:0] A_FLG2 = ADDR_W'(FLG2_ADDR);

    // R2: a channel flag never rises without an event in the prior cycle
    a_r2_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((chan_flags & ~$past(chan_flags) & ~$past(chan_evt)) == '0));

    // R3: written ones at the channel register clear flags without a coinciding event
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLG1)
        |=> ((chan_flags & $past(wdata[NUM_CH-1:0] & ~chan_evt)) == '0));

    // R4: rollover pulse sets the overflow flag
    a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    // R5: reserved bits of the channel register read zero, idle bus reads zero
    a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_FLG1) |-> (rdata[DATA_W-1:NUM_CH] == '0));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
    a_r5_ovf_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_FLG2) |-> (rdata == {ovf_flag, {(DATA_W-1){1'b0}}}));

    // R8: fast-clear counter read drops the overflow flag
    a_r8_cnt_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clr && rd_en && addr == A_CNT && !ovf_evt) |=> !ovf_flag);

    // R9: without fast-clear and without a flag write, set channel flags hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_clr && !(wr_en && addr == A_FLG1))
        |=> ((chan_flags & $past(chan_flags)) == $past(chan_flags)));

    // R10: an event wins over any clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_evt) |=> ((chan_flags & $past(chan_evt)) == $past(chan_evt)));

endmodule

bind tflag_regs tflag_regs_chk #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_ADDR (CNT_ADDR),
    .FLG1_ADDR(FLG1_ADDR),
    .FLG2_ADDR(FLG2_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_evt  (chan_evt),
    .ovf_evt   (ovf_evt),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .fast_clr  (fast_clr),
    .rdata     (rdata),
    .chan_flags(chan_flags),
    .ovf_flag  (ovf_flag)
);

// File: tb/tflag_regs_test.sv
module tflag_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_evt = '0;
    logic       ovf_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       fast_clr = 1'b0;
    logic [7:0] rdata;
    logic [3:0] chan_flags;
    logic       ovf_flag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state
    bit [3:0] m_ch  = '0;
    bit       m_ovf = 1'b0;

    always #5 clk = ~clk;

    tflag_regs uut (
        .clk(clk), .rst_n(rst_n), .chan_evt(chan_evt), .ovf_evt(ovf_evt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .fast_clr(fast_clr), .rdata(rdata), .chan_flags(chan_flags),
        .ovf_flag(ovf_flag)
    );

    function automatic bit [7:0] exp_rdata();
        if (!rd_en) return 8'h00;
        if (addr == 4'h6) return {4'h0, m_ch};
        if (addr == 4'h7) return {m_ovf, 7'h00};
        return 8'h00;
    endfunction

    task automatic compare_state(input string tag);
        vectors++;
        if (chan_flags !== m_ch || ovf_flag !== m_ovf) begin
            errors++;
            $display("FAIL %s flags: actual ch=%h ovf=%b expected ch=%h ovf=%b",
                     tag, chan_flags, ovf_flag, m_ch, m_ovf);
        end
    endtask

    task automatic step(input bit [3:0] e, input bit o, input bit w, input bit r,
                        input bit [3:0] a, input bit [7:0] d, input bit fc,
                        input string tag);
        bit [3:0] nxt;
        @(negedge clk);
        chan_evt = e; ovf_evt = o; wr_en = w; rd_en = r;
        addr = a; wdata = d; fast_clr = fc;
        #1;
        vectors++;
        if (rdata !== exp_rdata()) begin
            errors++;
            $display("FAIL %s rdata: actual %h expected %h", tag, rdata, exp_rdata());
        end
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            bit clr;
            clr = (w && a == 4'h6 && d[i]) || (fc && (w || r) && a == 4'(i));
            nxt[i] = e[i] ? 1'b1 : (clr ? 1'b0 : m_ch[i]);
        end
        m_ch = nxt;
        if (o) m_ovf = 1'b1;
        else if ((w && a == 4'h7 && d[7]) || (fc && r && a == 4'h4)) m_ovf = 1'b0;
        #1;
        compare_state(tag);
    endtask

    task automatic idle(input string tag);
        step(4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_state("R1");
        step(4'h0, 0, 0, 1, 4'h6, 8'h00, 0, "R1");
        step(4'h0, 0, 0, 1, 4'h7, 8'h00, 0, "R1");

        // R2 set and stickiness, R5 reads
        step(4'h5, 0, 0, 0, 4'h0, 8'h00, 0, "R2");
        idle("R2");
        step(4'h0, 0, 0, 1, 4'h6, 8'h00, 0, "R5");
        step(4'h0, 0, 0, 1, 4'h3, 8'h00, 0, "R5");
        step(4'h0, 0, 0, 1, 4'hA, 8'h00, 0, "R5");
        step(4'hA, 0, 0, 0, 4'h6, 8'hFF, 0, "R2");

        // R3 write-one-to-clear, zeros keep
        step(4'h0, 0, 1, 0, 4'h6, 8'h03, 0, "R3");
        step(4'h0, 0, 0, 1, 4'h6, 8'h00, 0, "R3");
        step(4'h0, 0, 1, 0, 4'h6, 8'h00, 0, "R3");
        step(4'h0, 0, 1, 0, 4'h6, 8'h0C, 0, "R3");

        // R4 overflow
        step(4'h0, 1, 0, 0, 4'h0, 8'h00, 0, "R4");
        step(4'h0, 0, 0, 1, 4'h7, 8'h00, 0, "R4");
        step(4'h0, 0, 1, 0, 4'h7, 8'h7F, 0, "R6");
        step(4'h0, 0, 1, 0, 4'h7, 8'h80, 0, "R4");

        // R6 reserved writes
        step(4'hF, 1, 0, 0, 4'h0, 8'h00, 0, "R6");
        step(4'h0, 0, 1, 0, 4'h6, 8'hF0, 0, "R6");
        step(4'h0, 0, 0, 1, 4'h6, 8'h00, 0, "R6");

        // R9 fast-clear off: data accesses do nothing
        for (int k = 0; k < 5; k++) begin
            step(4'h0, 0, 1, 1, 4'(k), 8'hFF, 0, "R9");
        end

        // R7 fast-clear on channel reads and writes
        step(4'h0, 0, 0, 1, 4'h1, 8'h00, 1, "R7");
        step(4'h0, 0, 1, 0, 4'h2, 8'h00, 1, "R7");
        step(4'h0, 0, 0, 1, 4'h4, 8'h00, 1, "R8");
        step(4'h0, 0, 1, 0, 4'h0, 8'h00, 1, "R7");
        step(4'h0, 0, 1, 0, 4'h3, 8'h00, 1, "R7");

        // R10 collisions
        step(4'h6, 1, 0, 0, 4'h0, 8'h00, 0, "R10");
        step(4'h2, 0, 1, 0, 4'h6, 8'h0F, 0, "R10");
        step(4'h4, 0, 0, 1, 4'h2, 8'h00, 1, "R10");
        step(4'h0, 1, 0, 1, 4'h4, 8'h00, 1, "R10");
        step(4'h0, 1, 1, 0, 4'h7, 8'h80, 0, "R10");

        // R11 repeated events
        step(4'h2, 0, 0, 0, 4'h0, 8'h00, 0, "R11");
        step(4'h2, 0, 0, 1, 4'h6, 8'h00, 0, "R11");

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            bit [3:0] e = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            step(e, 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                 4'($urandom_range(0, 8)), 8'($urandom), 1'($urandom),
                 "R2,R3,R4,R7,R8,R10");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule